// File: doc/BRIEF.md
# PS/2 Keyboard Receive Port

This block takes the two lines of a PS/2 keyboard and turns each scan code into a byte that a CPU reads over its data bus. The clock and data lines are plain inputs. The CPU system clock samples them through a synchronizer, and a falling edge of the keyboard clock is found by comparing two successive samples. No flip-flop is clocked by the keyboard. On each detected falling edge one bit of the serial frame is shifted in. When a whole frame has arrived and its framing and parity are correct, the byte is held and an interrupt request goes high.

The CPU reads the byte at the data address. The first cycle of that read acknowledges the key event and drops the request, so each scan code is taken once. The byte is the raw scan code, with no mapping to characters. A second address returns a small status byte. Its sticky overrun flag records that a byte was replaced before the CPU fetched it. Frames with bad framing or parity are dropped. If the keyboard clock stalls high part-way through a frame, the partial frame is abandoned.

Top module: `kbd_rx_port`

## Requirements
- R1: After reset, `irq_o` is 0, the data address reads 0x00, and the status address reads 0x00.
- R2: A frame is 11 bits, each taken on a falling edge of the sampled keyboard clock, in this order: a start bit of 0, eight data bits least-significant first, an odd-parity bit (data plus parity has an odd number of ones), and a stop bit of 1. A correct frame makes its eight data bits the held byte.
- R3: `rdata_o` is 0x00 unless `cs_i` and `rd_i` are both 1. During a read, address 0 returns the held byte and address 1 returns the status byte. Read data is valid in the first cycle of the read.
- R4: A frame with a start bit of 1, wrong parity, or a stop bit of 0 is discarded. It raises no interrupt and leaves the held byte unchanged.
- R5: `irq_o` rises a few system cycles after the stop bit of a correct frame, and stays high until the held byte is read.
- R6: A read of address 0 drops `irq_o` at the end of its first cycle. The held byte stays readable afterwards.
- R7: If the keyboard clock stays high for `IDLE_LIMIT` system cycles while a frame is partly received, the receiver returns to idle and discards the partial bits. The next frame is then received correctly.
- R8: If a correct frame completes while `irq_o` is still high, the new byte replaces the old one and status bit 0 (overrun) becomes 1. This flag is sticky and is cleared by a read of address 1. Status bit 1 shows the current value of `irq_o`. The other status bits read 0.
- R9: A status read does not clear `irq_o`, and a data read does not clear the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_clk_i | input | 1 | Keyboard clock line, idles high |
| kbd_dat_i | input | 1 | Keyboard data line, idles high |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register address: 0 data, 1 status |
| rdata_o | output | 8 | Read data, zero when not selected for a read |
| irq_o | output | 1 | Scan-code-ready interrupt request |

## Verification
Each fault in the internal state shows up at the ports within one frame.
- A slipped bit counter or a wrong shift direction corrupts the next byte read, and a sweep over all 256 codes exposes it.
- A missed frame check shows up as an interrupt where none should be. The byte read back is then no longer the last correct code.
- A timeout that never fires leaves stale bits in the shift register. The frame sent after a stall then reads back wrong.
- Errors in the acknowledge or overrun logic show in `irq_o` or the status byte on the very next bus read.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
   localparam int FRAME_BITS = 11;
   localparam int BYTE_W     = 8;

   typedef logic [BYTE_W-1:0] scan_t;

   typedef struct packed {
      logic [BYTE_W-3:0] zero;
      logic              pending;
      logic              overrun;
   } stat_t;

   function automatic logic odd_ok(input logic [BYTE_W:0] bits);
      return ^bits;
   endfunction
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kclk_i,
   input  logic kdat_i,
   output logic kdat_s,
   output logic kclk_high,
   output logic kclk_fall
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("kbd_line_sync: STAGES must be at least 2");
   end

   logic [TOP:0] c_sh;
   logic [TOP:0] d_sh;
   logic         c_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_sh   <= '1;
         d_sh   <= '1;
         c_prev <= 1'b1;
      end else begin
         c_sh   <= {c_sh[TOP-1:0], kclk_i};
         d_sh   <= {d_sh[TOP-1:0], kdat_i};
         c_prev <= c_sh[TOP];
      end
   end

   assign kdat_s    = d_sh[TOP];
   assign kclk_high = c_sh[TOP];
   assign kclk_fall = c_prev & ~c_sh[TOP];

   // R2
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kclk_fall |=> !kclk_fall);
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
   import kbd_rx_pkg::*;
#(
   parameter int IDLE_LIMIT = 5000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  kdat_s,
   input  logic  kclk_high,
   input  logic  kclk_fall,
   output logic  frm_valid,
   output scan_t frm_byte
);
   localparam int IDX_W  = $clog2(FRAME_BITS);
   localparam int CNT_W  = $clog2(IDLE_LIMIT + 1);
   localparam int LAST   = FRAME_BITS - 1;

   if (IDLE_LIMIT < 2) begin : g_bad_limit
      $error("kbd_frame_rx: IDLE_LIMIT must be at least 2");
   end

   logic [IDX_W-1:0]  bit_idx;
   logic [BYTE_W:0]   sh;
   logic              start_q;
   logic [CNT_W-1:0]  idle_cnt;
   logic              frame_good;

   assign frame_good = !start_q && kdat_s && odd_ok(sh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_idx   <= '0;
         sh        <= '0;
         start_q   <= 1'b1;
         idle_cnt  <= '0;
         frm_valid <= 1'b0;
         frm_byte  <= '0;
      end else begin
         frm_valid <= 1'b0;
         if (kclk_fall) begin
            idle_cnt <= '0;
            if (bit_idx == '0) begin
               start_q <= kdat_s;
               bit_idx <= IDX_W'(1);
            end else if (bit_idx != IDX_W'(LAST)) begin
               sh      <= {kdat_s, sh[BYTE_W:1]};
               bit_idx <= bit_idx + IDX_W'(1);
            end else begin
               bit_idx <= '0;
               if (frame_good) begin
                  frm_valid <= 1'b1;
                  frm_byte  <= sh[BYTE_W-1:0];
               end
            end
         end else if (bit_idx != '0 && kclk_high) begin
            if (idle_cnt == CNT_W'(IDLE_LIMIT - 1)) begin
               idle_cnt <= '0;
               bit_idx  <= '0;
            end else begin
               idle_cnt <= idle_cnt + CNT_W'(1);
            end
         end
      end
   end

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> bit_idx == '0);
   // R7
   idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt < CNT_W'(IDLE_LIMIT));
endmodule

// File: rtl/kbd_bus_regs.sv
module kbd_bus_regs
   import kbd_rx_pkg::*;
#(
   parameter int ADDR_W    = 1,
   parameter int DATA_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  scan_t             frm_byte,
   input  logic              cs_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output scan_t             rdata_o,
   output logic              irq_o
);
   if (DATA_ADDR == STAT_ADDR || DATA_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W))
   begin : g_bad_map
      $error("kbd_bus_regs: register addresses must differ and fit ADDR_W");
   end

   logic  acc, acc_q, first;
   logic  sel_dat, sel_st, dat_hit, st_hit;
   scan_t hold;
   logic  irq_q, ovr_q;
   stat_t stat;

   assign acc     = cs_i & rd_i;
   assign first   = acc & ~acc_q;
   assign sel_dat = addr_i == ADDR_W'(DATA_ADDR);
   assign sel_st  = addr_i == ADDR_W'(STAT_ADDR);
   assign dat_hit = first & sel_dat;
   assign st_hit  = first & sel_st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
         hold  <= '0;
         irq_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         acc_q <= acc;
         if (frm_valid) hold <= frm_byte;
         if (frm_valid)    irq_q <= 1'b1;
         else if (dat_hit) irq_q <= 1'b0;
         if (frm_valid && irq_q && !dat_hit) ovr_q <= 1'b1;
         else if (st_hit)                    ovr_q <= 1'b0;
      end
   end

   always_comb begin
      stat         = '0;
      stat.pending = irq_q;
      stat.overrun = ovr_q;
      rdata_o      = '0;
      if (acc && sel_dat)     rdata_o = hold;
      else if (acc && sel_st) rdata_o = stat;
   end

   assign irq_o = irq_q;

   // R5
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(frm_valid));
   // R6
   irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_hit && !frm_valid) |=> !irq_q);
   // R8
   ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(frm_valid && irq_q));
   // R9
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !st_hit) |=> ovr_q);
endmodule

// File: rtl/kbd_rx_port.sv
module kbd_rx_port
   import kbd_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_LIMIT  = 5000,
   parameter int ADDR_W      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kbd_clk_i,
   input  logic              kbd_dat_i,
   input  logic              cs_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [7:0]        rdata_o,
   output logic              irq_o
);
   logic  kdat_s, kclk_high, kclk_fall, frm_valid;
   scan_t frm_byte;

   kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .kclk_i(kbd_clk_i), .kdat_i(kbd_dat_i),
      .kdat_s(kdat_s), .kclk_high(kclk_high), .kclk_fall(kclk_fall));

   kbd_frame_rx #(.IDLE_LIMIT(IDLE_LIMIT)) u_frame (
      .clk(clk), .rst_n(rst_n), .kdat_s(kdat_s), .kclk_high(kclk_high),
      .kclk_fall(kclk_fall), .frm_valid(frm_valid), .frm_byte(frm_byte));

   kbd_bus_regs #(.ADDR_W(ADDR_W), .DATA_ADDR(0), .STAT_ADDR(1)) u_regs (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_byte(frm_byte),
      .cs_i(cs_i), .rd_i(rd_i), .addr_i(addr_i), .rdata_o(rdata_o), .irq_o(irq_o));
endmodule

// File: tb/kbd_rx_port_tb.sv
module kbd_rx_port_tb;
   localparam int LIMIT = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       kclk = 1'b1, kdat = 1'b1;
   logic       cs = 1'b0, rd = 1'b0;
   logic [0:0] addr = 1'b0;
   logic [7:0] rdata;
   logic       irq;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   kbd_rx_port #(.SYNC_STAGES(2), .IDLE_LIMIT(LIMIT), .ADDR_W(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .kbd_clk_i(kclk), .kbd_dat_i(kdat),
      .cs_i(cs), .rd_i(rd), .addr_i(addr), .rdata_o(rdata), .irq_o(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [10:0] f, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         kdat = f[i];
         wait_clk(4);
         kclk = 1'b0;
         wait_clk(8);
         kclk = 1'b1;
         wait_clk(4);
      end
      kdat = 1'b1;
      wait_clk(10);
   endtask

   function automatic logic [10:0] mk(input logic [7:0] b, input logic st,
                                      input logic pflip, input logic sp);
      return {sp, (~^b) ^ pflip, b, st};
   endfunction

   task automatic bus_rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = a;
      #5 v = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      chk("R1 irq", irq, 0);
      bus_rd(1'b0, v); chk("R1 data", v, 8'h00);
      bus_rd(1'b1, v); chk("R1 status", v, 8'h00);

      // R2 R5 R6: every scan code
      for (int b = 0; b < 256; b++) begin
         send_bits(mk(8'(b), 1'b0, 1'b0, 1'b1), 11);
         chk("R5 irq raised", irq, 1);
         bus_rd(1'b0, v);
         chk("R2 byte", v, b);
         chk("R6 irq cleared", irq, 0);
      end
      bus_rd(1'b0, v); chk("R6 byte kept", v, 8'hFF);

      // R3 strobe gating
      send_bits(mk(8'h3C, 1'b0, 1'b0, 1'b1), 11);
      @(negedge clk); cs = 1'b1; rd = 1'b0; addr = 1'b0;
      #5 chk("R3 no rd", rdata, 0);
      @(negedge clk); cs = 1'b0; rd = 1'b1;
      #5 chk("R3 no cs", rdata, 0);
      @(negedge clk); rd = 1'b0;
      chk("R3 irq untouched", irq, 1);
      // R9 status read keeps irq
      bus_rd(1'b1, v); chk("R9 status pending", v, 8'h02);
      chk("R9 irq kept", irq, 1);
      bus_rd(1'b0, v); chk("R3 data", v, 8'h3C);

      // R4 bad frames
      for (int k = 0; k < 16; k++) begin
         logic [7:0] b;
         b = 8'(k * 17 + 5);
         send_bits(mk(b, 1'b0, 1'b1, 1'b1), 11);
         chk("R4 parity irq", irq, 0);
         send_bits(mk(b, 1'b0, 1'b0, 1'b0), 11);
         chk("R4 stop irq", irq, 0);
         send_bits(mk(b, 1'b1, 1'b0, 1'b1), 11);
         chk("R4 start irq", irq, 0);
         bus_rd(1'b0, v); chk("R4 byte kept", v, 8'h3C);
      end

      // R7 stall mid-frame
      for (int n = 1; n < 11; n++) begin
         send_bits(mk(8'hA5, 1'b0, 1'b0, 1'b1), n);
         wait_clk(LIMIT + 10);
         send_bits(mk(8'(n + 8'h50), 1'b0, 1'b0, 1'b1), 11);
         chk("R7 irq", irq, 1);
         bus_rd(1'b0, v); chk("R7 byte", v, n + 8'h50);
      end

      // R8 overrun
      send_bits(mk(8'h11, 1'b0, 1'b0, 1'b1), 11);
      send_bits(mk(8'h22, 1'b0, 1'b0, 1'b1), 11);
      bus_rd(1'b0, v); chk("R8 overwrite", v, 8'h22);
      bus_rd(1'b0, v);
      bus_rd(1'b1, v); chk("R9 ovr kept after data read", v, 8'h01);
      bus_rd(1'b1, v); chk("R8 ovr cleared", v, 8'h00);
      send_bits(mk(8'h33, 1'b0, 1'b0, 1'b1), 11);
      send_bits(mk(8'h44, 1'b0, 1'b0, 1'b1), 11);
      bus_rd(1'b1, v); chk("R8 status both", v, 8'h03);
      chk("R8 irq still", irq, 1);
      bus_rd(1'b0, v); chk("R8 byte", v, 8'h44);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule